// File: doc/BRIEF.md
# Virtual Address Access Checker

This block makes the front-end decision for each memory access of a 32-bit core with paged translation. It takes a virtual address with its access kind (read, write or instruction fetch) and the privilege level. It sorts the address into a region: direct-mapped, translated, or forbidden. It then decides whether the access bypasses translation. For translated accesses it combines the address with the page lookup result supplied alongside the request. That result is a hit or multi-hit indication, the page frame, the page-size mask, the two protection bits and the dirty bit. From these it applies the protection and first-write rules.

Requests enter over a valid/ready handshake. Each result is held in one output register that is also valid/ready. A request is accepted only when the register is empty or is being drained in the same cycle, so back-pressure on the output stalls the input directly. Nothing is dropped. A held result does not change until it is taken. The address-space-match enable for the page lookup is a plain combinational output, computed from the request currently offered. The lookup can use it in the same cycle.

Each result carries three things. The first is a pass-through flag. The second is a one-hot fault code. The third is a 33-bit result word: bit 32 flags a fault, and the low 32 bits hold the physical address, or zero when there is a fault.

Top module: `vac_access_check`

## Requirements
- R1: A request is accepted on a clock edge where `in_valid` and `in_ready` are both high. Its result appears with `out_valid` high after that edge. While `out_valid` is high and `out_ready` is low, the result stays unchanged and `in_ready` is low. `in_ready` equals `!out_valid || out_ready`.
- R2: `asid_en` is high whenever the single-space mode bit is low or the request is unprivileged. It is low only for a privileged request with single-space mode set. It follows the inputs in the same cycle.
- R3: An unprivileged access to any address with bit 31 set gives an address error.
- R4: A privileged access to an address in [0x8000_0000, 0xC000_0000) passes through untranslated, whether or not translation is enabled. The physical address equals the virtual address.
- R5: A privileged read or write at or above 0xE000_0000 gives an address error. A privileged fetch at or above 0xFFFF_FF00 is treated like a translated address. A privileged fetch in [0xE000_0000, 0xFFFF_FF00) gives an address error.
- R6: With translation disabled, every address that is not an address error passes through unchanged. The lookup inputs have no effect in that case.
- R7: For a translated access, `tlb_hit` and `tlb_multi` both low gives a miss fault. `tlb_multi` high gives a multi-hit fault.
- R8: The protection field has bit 0 as the writable bit and bit 1 as the user-access bit. A privileged write faults when bit 0 is clear. An unprivileged write faults unless both bits are set.
- R9: An unprivileged read or fetch faults when protection bit 1 is clear. Privileged reads and fetches never take a protection fault.
- R10: A translated write that passes protection, to a page whose dirty bit is clear, gives an initial-write fault.
- R11: On success the physical address is `(tlb_ppn & tlb_mask) | (addr & ~tlb_mask)` for translated accesses and `addr` for pass-through. Result word bit 32 is 1 exactly when a fault is reported, with the low 32 bits zero.
- R12: `out_fault` is one-hot or zero. Bit 0 is address error, bit 1 is miss, bit 2 is multi-hit, bit 3 is protection and bit 4 is initial write. The lower bit wins when several apply. Access kind 2'b00 is read, 2'b01 is write and 2'b10 is fetch. Kind 2'b11 behaves as read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Request can be taken this cycle |
| in_addr | input | 32 | Virtual address |
| in_kind | input | 2 | Access kind: 00 read, 01 write, 10 fetch |
| in_priv | input | 1 | Privileged mode |
| in_xlat_en | input | 1 | Translation enable |
| in_single_vm | input | 1 | Single-space mode |
| tlb_hit | input | 1 | Lookup found exactly one entry |
| tlb_multi | input | 1 | Lookup found more than one entry |
| tlb_ppn | input | 32 | Page frame of the matching entry |
| tlb_mask | input | 32 | Page mask of the matching entry (ones over frame bits) |
| tlb_prot | input | 2 | Protection: bit 1 user access, bit 0 writable |
| tlb_dirty | input | 1 | Dirty bit of the matching entry |
| asid_en | output | 1 | Lookup must compare the address-space identifier |
| out_valid | output | 1 | Result held |
| out_ready | input | 1 | Result taken this cycle |
| out_pass | output | 1 | Access bypassed translation |
| out_fault | output | 5 | One-hot fault code |
| out_word | output | 33 | Bit 32 fault flag; low bits physical address |

## Verification
The assertions assume a few things about the inputs. They assume the requester keeps `in_valid` and the request fields steady for the cycle it offers them. They assume the lookup result for a translated access arrives together with the address. They also assume `tlb_mask` is a contiguous run of high ones. The stimulus offers each request from the falling edge and withdraws it after exactly one accepting edge. It draws page masks only from 1 KB and 1 MB page sizes, and it stalls the output now and then to exercise the hold rule.

// File: rtl/vac_pkg.sv
package vac_pkg;
  localparam int ADDR_W  = 32;
  localparam int FAULT_W = 5;
  localparam int WORD_W  = ADDR_W + 1;

  // fault bit positions, lowest index has highest priority
  localparam int F_ADDR  = 0;
  localparam int F_MISS  = 1;
  localparam int F_MULTI = 2;
  localparam int F_PROT  = 3;
  localparam int F_INITW = 4;

  typedef enum logic [1:0] {
    K_READ  = 2'b00,
    K_WRITE = 2'b01,
    K_FETCH = 2'b10,
    K_RSVD  = 2'b11
  } kind_e;

  localparam logic [ADDR_W-1:0] DIRECT_LO   = 32'h8000_0000;
  localparam logic [ADDR_W-1:0] DIRECT_HI   = 32'hC000_0000;
  localparam logic [ADDR_W-1:0] FORBID_LO   = 32'hE000_0000;
  localparam logic [ADDR_W-1:0] FETCH_WIN   = 32'hFFFF_FF00;

  typedef struct packed {
    logic              pass;
    logic [FAULT_W-1:0] fault;
    logic [WORD_W-1:0]  word;
  } result_t;
endpackage

// File: rtl/vac_region.sv
module vac_region
  import vac_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        kind,
  input  logic              priv,
  input  logic              xlat_en,
  output logic              addr_err,
  output logic              bypass,
  output logic              xlat
);
  logic low_half, direct_win, mid_win, fetch_top;

  always_comb begin
    low_half   = !addr[ADDR_W-1];
    direct_win = (addr >= DIRECT_LO) && (addr < DIRECT_HI);
    mid_win    = (addr >= DIRECT_HI) && (addr < FORBID_LO);
    fetch_top  = (kind == K_FETCH) && (addr >= FETCH_WIN);

    addr_err = 1'b0;
    bypass   = 1'b0;
    xlat     = 1'b0;
    if (!priv) begin
      if (!low_half) begin
        addr_err = 1'b1;
      end else begin
        xlat   = xlat_en;
        bypass = !xlat_en;
      end
    end else if (direct_win) begin
      bypass = 1'b1;
    end else if (low_half || mid_win || fetch_top) begin
      xlat   = xlat_en;
      bypass = !xlat_en;
    end else begin
      addr_err = 1'b1;
    end
  end
endmodule

// File: rtl/vac_prot.sv
module vac_prot
  import vac_pkg::*;
(
  input  logic [1:0] kind,
  input  logic       priv,
  input  logic [1:0] prot,
  input  logic       dirty,
  output logic       prot_fault,
  output logic       initw_fault
);
  logic is_write;

  always_comb begin
    is_write = (kind == K_WRITE);
    if (is_write) begin
      prot_fault = priv ? !prot[0] : (prot != 2'b11);
    end else begin
      prot_fault = !priv && !prot[1];
    end
    initw_fault = is_write && !dirty;
  end
endmodule

// File: rtl/vac_fault_sel.sv
module vac_fault_sel #(
  parameter int N = 5
) (
  input  logic [N-1:0] raw,
  output logic [N-1:0] sel
);
  logic [N:0] blocked;
  assign blocked[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_pri
    assign sel[i]       = raw[i] && !blocked[i];
    assign blocked[i+1] = blocked[i] || raw[i];
  end
endmodule

// File: rtl/vac_outreg.sv
module vac_outreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end
endmodule

// File: rtl/vac_access_check.sv
module vac_access_check
  import vac_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int FW = FAULT_W,
  localparam int WW = AW + 1,
  localparam int RW = 1 + FW + WW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [AW-1:0] in_addr,
  input  logic [1:0]    in_kind,
  input  logic          in_priv,
  input  logic          in_xlat_en,
  input  logic          in_single_vm,
  input  logic          tlb_hit,
  input  logic          tlb_multi,
  input  logic [AW-1:0] tlb_ppn,
  input  logic [AW-1:0] tlb_mask,
  input  logic [1:0]    tlb_prot,
  input  logic          tlb_dirty,
  output logic          asid_en,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          out_pass,
  output logic [FW-1:0] out_fault,
  output logic [WW-1:0] out_word
);
  logic addr_err, bypass, xlat;
  logic prot_f, initw_f;
  logic [FW-1:0] raw_f, sel_f;
  logic [AW-1:0] phys;
  result_t nxt, cur;

  assign asid_en = !in_single_vm || !in_priv;

  vac_region u_region (
    .addr(in_addr), .kind(in_kind), .priv(in_priv), .xlat_en(in_xlat_en),
    .addr_err(addr_err), .bypass(bypass), .xlat(xlat)
  );

  vac_prot u_prot (
    .kind(in_kind), .priv(in_priv), .prot(tlb_prot), .dirty(tlb_dirty),
    .prot_fault(prot_f), .initw_fault(initw_f)
  );

  always_comb begin
    raw_f          = '0;
    raw_f[F_ADDR]  = addr_err;
    raw_f[F_MISS]  = xlat && !tlb_hit && !tlb_multi;
    raw_f[F_MULTI] = xlat && tlb_multi;
    raw_f[F_PROT]  = xlat && prot_f;
    raw_f[F_INITW] = xlat && initw_f;
  end

  vac_fault_sel #(.N(FW)) u_sel (.raw(raw_f), .sel(sel_f));

  always_comb begin
    phys = xlat ? ((tlb_ppn & tlb_mask) | (in_addr & ~tlb_mask)) : in_addr;
    nxt.fault = sel_f;
    nxt.pass  = bypass && !(|sel_f);
    nxt.word  = (|sel_f) ? {1'b1, {AW{1'b0}}} : {1'b0, phys};
  end

  vac_outreg #(.W(RW)) u_out (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(nxt),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(cur)
  );

  assign out_pass  = cur.pass;
  assign out_fault = cur.fault;
  assign out_word  = cur.word;
endmodule

// File: rtl/vac_access_check_chk.sv
module vac_access_check_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        in_priv,
  input logic        in_single_vm,
  input logic        asid_en,
  input logic        out_valid,
  input logic        out_ready,
  input logic        out_pass,
  input logic [4:0]  out_fault,
  input logic [32:0] out_word
);
  // R1
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_word) && $stable(out_fault) && $stable(out_pass));

  // R1
  stall_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R1
  accept_shows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R2
  asid_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_priv && in_single_vm |-> !asid_en);

  // R12
  fault_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0(out_fault));

  // R11
  fault_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_word[32] == (out_fault != 5'd0)));

  // R11
  fault_zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_word[32] |-> (out_word[31:0] == 32'd0) && !out_pass);
endmodule

bind vac_access_check vac_access_check_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_priv(in_priv), .in_single_vm(in_single_vm), .asid_en(asid_en),
  .out_valid(out_valid), .out_ready(out_ready), .out_pass(out_pass),
  .out_fault(out_fault), .out_word(out_word)
);

// File: tb/vac_access_check_tb.sv
module vac_access_check_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_addr = '0;
  logic [1:0]  in_kind = '0;
  logic        in_priv = 1'b0, in_xlat_en = 1'b0, in_single_vm = 1'b0;
  logic        tlb_hit = 1'b0, tlb_multi = 1'b0;
  logic [31:0] tlb_ppn = '0, tlb_mask = '0;
  logic [1:0]  tlb_prot = '0;
  logic        tlb_dirty = 1'b0;
  logic        asid_en;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic        out_pass;
  logic [4:0]  out_fault;
  logic [32:0] out_word;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vac_access_check u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_kind(in_kind), .in_priv(in_priv),
    .in_xlat_en(in_xlat_en), .in_single_vm(in_single_vm),
    .tlb_hit(tlb_hit), .tlb_multi(tlb_multi), .tlb_ppn(tlb_ppn),
    .tlb_mask(tlb_mask), .tlb_prot(tlb_prot), .tlb_dirty(tlb_dirty),
    .asid_en(asid_en), .out_valid(out_valid), .out_ready(out_ready),
    .out_pass(out_pass), .out_fault(out_fault), .out_word(out_word)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h addr=%08h kind=%0d priv=%0b at=%0b hit=%0b multi=%0b prot=%0b dirty=%0b",
               req, act, exp, in_addr, in_kind, in_priv, in_xlat_en, tlb_hit, tlb_multi, tlb_prot, tlb_dirty);
    end
  endtask

  function automatic logic [31:0] pick_addr(input int i);
    case (i)
      0: return 32'h0000_0000;   1: return 32'h0000_1234;
      2: return 32'h7FFF_FFFF;   3: return 32'h8000_0000;
      4: return 32'h9ABC_DEF0;   5: return 32'hBFFF_FFFF;
      6: return 32'hC000_0000;   7: return 32'hC123_4567;
      8: return 32'hDFFF_FFFF;   9: return 32'hE000_0000;
      10: return 32'hF000_0000;  11: return 32'hFFFF_FEFF;
      12: return 32'hFFFF_FF00;  13: return 32'hFFFF_FFFF;
      default: return 32'h4000_1FFC;
    endcase
  endfunction

  // reference model built from the requirement text
  logic [4:0]  e_fault;
  logic        e_pass;
  logic [32:0] e_word;
  string       e_tag;

  task automatic model();
    bit ae = 0, byp = 0, xl = 0, wr, pf;
    logic [31:0] a = in_addr;
    wr = (in_kind == 2'b01);
    if (!in_priv) begin
      if (a[31]) ae = 1; else begin xl = in_xlat_en; byp = !in_xlat_en; end
    end else if (a < 32'h8000_0000) begin
      xl = in_xlat_en; byp = !in_xlat_en;
    end else if (a < 32'hC000_0000) begin
      byp = 1;
    end else if (a < 32'hE000_0000 || (in_kind == 2'b10 && a >= 32'hFFFF_FF00)) begin
      xl = in_xlat_en; byp = !in_xlat_en;
    end else ae = 1;
    e_fault = 5'd0;
    e_tag = byp ? (in_priv && a[31] && a < 32'hC000_0000 ? "R4" : "R6") : "R11";
    if (ae) begin e_fault = 5'b00001; e_tag = in_priv ? "R5" : "R3"; end
    else if (xl) begin
      if (wr) pf = in_priv ? !tlb_prot[0] : (tlb_prot != 2'b11);
      else    pf = !in_priv && !tlb_prot[1];
      if (!tlb_hit && !tlb_multi) begin e_fault = 5'b00010; e_tag = "R7"; end
      else if (tlb_multi)         begin e_fault = 5'b00100; e_tag = "R7"; end
      else if (pf) begin e_fault = 5'b01000; e_tag = wr ? "R8" : "R9"; end
      else if (wr && !tlb_dirty) begin e_fault = 5'b10000; e_tag = "R10"; end
    end
    e_pass = byp && (e_fault == 0);
    if (e_fault != 0) e_word = {1'b1, 32'd0};
    else if (xl) e_word = {1'b0, (tlb_ppn & tlb_mask) | (a & ~tlb_mask)};
    else e_word = {1'b0, a};
  endtask

  task automatic run_one(input bit stall);
    @(negedge clk);
    in_valid = 1'b1;
    #1;
    check("R2", {63'd0, asid_en}, {63'd0, (!in_single_vm || !in_priv)});
    check("R1", {63'd0, in_ready}, 64'd1);
    model();
    @(negedge clk);
    in_valid = 1'b0;
    check("R1", {63'd0, out_valid}, 64'd1);
    check({e_tag, " R12"}, {59'd0, out_fault}, {59'd0, e_fault});
    check({e_tag, " R11"}, {31'd0, out_word}, {31'd0, e_word});
    check(e_tag, {63'd0, out_pass}, {63'd0, e_pass});
    if (stall) begin
      @(negedge clk);
      check("R1", {63'd0, in_ready}, 64'd0);
      check("R1", {31'd0, out_word}, {31'd0, e_word});
      check("R1", {63'd0, out_valid}, 64'd1);
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    check("R1", {63'd0, out_valid}, 64'd0);
  endtask

  initial begin
    int n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {63'd0, out_valid}, 64'd0);
    check("R1", {63'd0, in_ready}, 64'd1);
    for (int ai = 0; ai < 15; ai++)
      for (int pv = 0; pv < 2; pv++)
        for (int kd = 0; kd < 3; kd++)
          for (int at = 0; at < 2; at++)
            for (int sv = 0; sv < 2; sv++)
              for (int hm = 0; hm < 3; hm++)
                for (int pr = 0; pr < 4; pr++)
                  for (int dt = 0; dt < 2; dt++) begin
                    in_addr      = pick_addr(ai);
                    in_priv      = pv[0];
                    in_kind      = kd[1:0];
                    in_xlat_en   = at[0];
                    in_single_vm = sv[0];
                    tlb_hit      = (hm == 1);
                    tlb_multi    = (hm == 2);
                    tlb_prot     = pr[1:0];
                    tlb_dirty    = dt[0];
                    tlb_mask     = n[0] ? 32'hFFF0_0000 : 32'hFFFF_FC00;
                    tlb_ppn      = 32'h0ABC_D400 ^ {n[15:0], 16'h0};
                    run_one((n % 97) == 5);
                    n++;
                  end
    // kind 11 behaves as read (R12)
    in_addr = 32'h0000_2000; in_priv = 0; in_kind = 2'b11; in_xlat_en = 1;
    tlb_hit = 1; tlb_multi = 0; tlb_prot = 2'b00; tlb_dirty = 0;
    run_one(0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule